// File: doc/BRIEF.md
# Digital Constant Fraction Discriminator

This block takes a stream of signed waveform samples, one per clock, and marks the sample at which a pulse crosses a fixed fraction of its own height. The timing mark it gives is independent of pulse amplitude. It is meant for negative-going detector pulses.

One path holds the incoming sample in a run-time selectable register delay of 1 to 15 samples. A second path takes the present sample, scales it by an unsigned fraction F/256 (arithmetic right shift, so rounding is toward minus infinity) and subtracts it from the delayed sample. The difference is registered. A one-cycle strobe is raised when that registered sum has just turned from zero-or-positive to negative.

Two conditions gate each strobe. An arming condition is needed: some delayed sample below a programmable level since the last strobe. A programmable hold-off time after each strobe must also have run out. With every strobe the block also latches a free-running 16-bit sample counter as a coarse timestamp.

Top module: `cfd_trigger`

## Requirements
- R1: While `rst_n` is low at a rising edge, and in the cycle after, `strobe` is 0 and `stamp` is 0, whatever the other inputs are.
- R2: At each rising edge the block registers S = D − floor(X·F/256). X is the signed `sample_in` present at that edge, F is the unsigned `frac`, and D is the sample that was present N edges earlier.
- R3: `strobe` is high for exactly the one cycle after the edge at which the registered S is negative and the S registered one edge earlier is zero or positive. It is never high two cycles in a row.
- R4: A strobe needs the block to be armed. It becomes armed at an edge where D is strictly less than `arm_level` (signed compare), and this includes the edge that registers the crossing value of S.
- R5: Every strobe clears the armed state. A later crossing produces no strobe unless a new D below `arm_level` has been seen.
- R6: After a strobe, the next `holdoff_len` crossing opportunities (rising edges) are blocked. With `holdoff_len` = 0, only the arming rule applies.
- R7: `stamp` takes the value of a 16-bit counter on each strobe and holds it otherwise. The counter is 0 after reset and counts up by one at every later edge. The strobe produced at the k-th edge after reset release carries stamp k−1.
- R8: N equals `delay_len` for values 1 to 15. A `delay_len` of 0 behaves as 1.
- R9: The internal sum is 22 bits signed and never overflows for any 12-bit sample and any 8-bit fraction. Full-scale inputs still give the exact value of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_in | input | 12 | Signed waveform sample, one per clock |
| delay_len | input | 4 | Delay N in samples (0 acts as 1) |
| frac | input | 8 | Unsigned fraction F, scale F/256 |
| arm_level | input | 12 | Signed arming level compared to the delayed sample |
| holdoff_len | input | 8 | Cycles blocked after each strobe |
| strobe | output | 1 | One-cycle crossing mark |
| stamp | output | 16 | Counter value latched at the last strobe |

## Verification
The assertions assume that `delay_len`, `frac`, `arm_level` and `holdoff_len` are settled configuration. They assume these inputs change only while reset is applied, so that crossing, arming and hold-off relate to one set of values. The stimulus follows this by loading each configuration with reset held low, then driving zeros, one or two pulses, and long zero tails with every sample inside the 12-bit range. The bench compares every cycle against its own model of R2 to R7 and also counts strobes per pulse train.

// File: rtl/cfd_pkg.sv
// Shared types for the constant fraction discriminator.
// Assumes: nothing beyond the standard.
package cfd_pkg;
    // Sign of the registered sum now and one sample earlier.
    typedef struct packed {
        logic now_neg;
        logic was_neg;
    } sign_hist_t;
endpackage

// File: rtl/cfd_delay_line.sv
// Register delay line with a selectable tap.
// What it does: keeps the last DEPTH samples and returns the one taken
// len edges ago (len 0 acts as 1, len above DEPTH acts as DEPTH).
// Assumes: len is steady while samples flow.
module cfd_delay_line #(
    parameter int W     = 12,
    parameter int DEPTH = 15,
    parameter int SEL_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] din,
    input  logic [SEL_W-1:0]    len,
    output logic signed [W-1:0] tap
);
    logic signed [W-1:0] stage [DEPTH];
    int idx;
    logic primed;

    // Shift the chain by one sample per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
        end else begin
            stage[0] <= din;
            for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
        end
    end

    // Map the requested length onto a stage index.
    always_comb begin
        int li;
        li = int'(len);
        if (li == 0)          idx = 0;
        else if (li > DEPTH)  idx = DEPTH - 1;
        else                  idx = li - 1;
    end

    // Pick the selected stage.
    always_comb begin
        tap = '0;
        for (int k = 0; k < DEPTH; k++) if (k == idx) tap = stage[k];
    end

    // Mark the cycles in which a past input value is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // R8: a length of 0 or 1 gives exactly one sample of delay.
    assert_unit_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && len <= SEL_W'(1)) |-> (tap == $past(din)))
        else $error("delay line tap is not the previous sample");
endmodule

// File: rtl/cfd_sum_stage.sv
// Scale-and-subtract stage.
// What it does: registers delayed - floor(current * frac / 2**FRAC_W) at
// SUM_W bits, and keeps the sign of this and of the previous sum.
// Assumes: SUM_W exceeds W + FRAC_W + 1.
module cfd_sum_stage
    import cfd_pkg::*;
#(
    parameter int W      = 12,
    parameter int FRAC_W = 8,
    parameter int SUM_W  = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] delayed,
    input  logic signed [W-1:0] current,
    input  logic [FRAC_W-1:0]   frac,
    output sign_hist_t          signs
);
    localparam int P_W = W + FRAC_W + 1;

    logic signed [FRAC_W:0]    frac_s;
    logic signed [P_W-1:0]     prod;
    logic signed [P_W-1:0]     scaled;
    logic signed [SUM_W-1:0]   sum_next;
    logic signed [SUM_W-1:0]   sum_q;

    // Form the scaled, inverted current sample plus the delayed sample.
    always_comb begin
        frac_s   = $signed({1'b0, frac});
        prod     = current * frac_s;
        scaled   = prod >>> FRAC_W;
        sum_next = {{(SUM_W-W){delayed[W-1]}}, delayed}
                 - {{(SUM_W-P_W){scaled[P_W-1]}}, scaled};
    end

    // Register the sum and the previous sign.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q         <= '0;
            signs.was_neg <= 1'b0;
        end else begin
            sum_q         <= sum_next;
            signs.was_neg <= sum_q[SUM_W-1];
        end
    end

    assign signs.now_neg = sum_q[SUM_W-1];

    // R9: the registered sum stays within the reach of two full-scale terms.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_q >= -(2**W)) && (sum_q <= 2**W))
        else $error("sum outside its expected range");
endmodule

// File: rtl/cfd_gate.sv
// Strobe qualification.
// What it does: raises a one-cycle strobe on a non-negative to negative
// step of the sum while armed and outside hold-off, and latches the
// sample counter as a timestamp.
// Assumes: arm_level and holdoff_len are steady while samples flow.
module cfd_gate
    import cfd_pkg::*;
#(
    parameter int W       = 12,
    parameter int HOLD_W  = 8,
    parameter int STAMP_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  sign_hist_t           signs,
    input  logic signed [W-1:0]  delayed,
    input  logic signed [W-1:0]  arm_level,
    input  logic [HOLD_W-1:0]    holdoff_len,
    output logic                 strobe,
    output logic [STAMP_W-1:0]   stamp
);
    logic                fire;
    logic                armed;
    logic [HOLD_W-1:0]   hold_cnt;
    logic [STAMP_W-1:0]  count;

    // Decide whether this edge produces a strobe.
    always_comb fire = signs.now_neg && !signs.was_neg && armed && (hold_cnt == '0);

    // Free-running sample counter.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end

    // Hold-off countdown, reloaded on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)              hold_cnt <= '0;
        else if (fire)           hold_cnt <= holdoff_len;
        else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
    end

    // Arm on a deep delayed sample, disarm on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                  armed <= 1'b0;
        else if (fire)               armed <= 1'b0;
        else if (delayed < arm_level) armed <= 1'b1;
    end

    // Register the strobe and its timestamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= 1'b0;
            stamp  <= '0;
        end else begin
            strobe <= fire;
            if (fire) stamp <= count;
        end
    end

    // R3: a strobe lasts one cycle.
    assert_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe) else $error("strobe longer than one cycle");
    // R3: a strobe follows a sign step of the sum.
    assert_crossing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> ($past(signs.now_neg) && !$past(signs.was_neg)))
        else $error("strobe without a crossing");
    // R4: a strobe needs the armed state.
    assert_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(armed)) else $error("strobe while unarmed");
    // R5: the strobe leaves the block disarmed.
    assert_disarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !armed) else $error("still armed after strobe");
    // R6: no strobe while hold-off runs.
    assert_holdoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_cnt != '0) |=> !strobe) else $error("strobe inside hold-off");
    // R7: the timestamp changes only with a strobe.
    assert_stamp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |-> $stable(stamp)) else $error("stamp moved without strobe");
endmodule

// File: rtl/cfd_trigger.sv
// Digital constant fraction discriminator, top level.
// What it does: delays the sample stream, subtracts a scaled copy of the
// present sample, and marks the sign step of the sum with a strobe and
// a coarse timestamp.
// Assumes: configuration inputs change only under reset.
module cfd_trigger
    import cfd_pkg::*;
#(
    parameter int  SAMPLE_W  = 12,
    parameter int  FRAC_W    = 8,
    parameter int  MAX_DELAY = 15,
    parameter int  HOLD_W    = 8,
    parameter int  STAMP_W   = 16,
    parameter int  SUM_W     = 22,
    localparam int DLY_W     = $clog2(MAX_DELAY + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    input  logic [DLY_W-1:0]           delay_len,
    input  logic [FRAC_W-1:0]          frac,
    input  logic signed [SAMPLE_W-1:0] arm_level,
    input  logic [HOLD_W-1:0]          holdoff_len,
    output logic                       strobe,
    output logic [STAMP_W-1:0]         stamp
);
    logic signed [SAMPLE_W-1:0] delayed;
    sign_hist_t                 signs;

    cfd_delay_line #(.W(SAMPLE_W), .DEPTH(MAX_DELAY), .SEL_W(DLY_W)) u_delay (
        .clk(clk), .rst_n(rst_n), .din(sample_in), .len(delay_len), .tap(delayed)
    );

    cfd_sum_stage #(.W(SAMPLE_W), .FRAC_W(FRAC_W), .SUM_W(SUM_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .delayed(delayed), .current(sample_in),
        .frac(frac), .signs(signs)
    );

    cfd_gate #(.W(SAMPLE_W), .HOLD_W(HOLD_W), .STAMP_W(STAMP_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .signs(signs), .delayed(delayed),
        .arm_level(arm_level), .holdoff_len(holdoff_len),
        .strobe(strobe), .stamp(stamp)
    );
endmodule

// File: tb/cfd_trigger_test.sv
module cfd_trigger_test;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [11:0] sample_in = '0;
    logic [3:0]         delay_len = 4'd2;
    logic [7:0]         frac = 8'd128;
    logic signed [11:0] arm_level = -12'sd1;
    logic [7:0]         holdoff_len = '0;
    logic               strobe;
    logic [15:0]        stamp;

    int tests = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cfd_trigger uut (
        .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .delay_len(delay_len),
        .frac(frac), .arm_level(arm_level), .holdoff_len(holdoff_len),
        .strobe(strobe), .stamp(stamp)
    );

    // Fields: shape(0 four-sample,1 spike), A1, A2, N, F, ARM, HOLD, expected strobes, tag
    localparam int ROWS = 14;
    localparam int TBL [ROWS][9] = '{
        '{0,  800,   0,  2, 128,   -1,   0, 1, 2},  // R2 R3 basic half fraction
        '{0,  800,   0,  1, 128,   -1,   0, 1, 8},  // R8 shortest delay
        '{0, 2000,   0,  5,  64,   -1,   0, 1, 2},  // R2 quarter fraction
        '{0,  800,   0,  2,   0,   -1,   0, 1, 2},  // R2 zero fraction
        '{0,  800,   0,  2, 255,   -1,   0, 1, 2},  // R2 largest fraction, floor rounding
        '{0,  800,   0,  2, 128, -900,   0, 0, 4},  // R4 never armed
        '{0,  800,   0, 15, 128,   -1,   0, 1, 8},  // R8 longest delay
        '{0,  800, 800,  2, 128,   -1,   0, 2, 6},  // R6 no hold-off
        '{0,  800, 800,  2, 128,   -1, 100, 1, 6},  // R6 second pulse inside hold-off
        '{1,  800, 200,  1,   0, -300,   0, 1, 5},  // R5 shallow second spike not rearmed
        '{1,  800, 800,  1,   0, -300,   0, 2, 5},  // R5 deep second spike rearms
        '{0,  800,   0,  0, 128,   -1,   0, 1, 8},  // R8 length 0 acts as 1
        '{0, 2048,   0,  2, 255,   -1,   0, 1, 9},  // R9 full-scale input
        '{0, -800,   0,  2, 128,   -1,   0, 0, 4}   // R4 positive pulse never arms
    };

    // Reference model state
    int m_sum, m_prevneg, m_armed, m_hold, m_count, m_stamp, m_strobe;
    int hist [16];
    int cfg_n, cfg_f, cfg_arm, cfg_hold;
    int ec, mism, nstrobe;
    int s_ec [2];
    int s_st [2];

    task automatic model_reset();
        m_sum = 0; m_prevneg = 0; m_armed = 0; m_hold = 0;
        m_count = 0; m_stamp = 0; m_strobe = 0; ec = 0;
        for (int k = 0; k < 16; k++) hist[k] = 0;
    endtask

    task automatic model_edge(input int x);
        int d, fire;
        d = hist[cfg_n - 1];
        fire = (m_sum < 0) && !m_prevneg && m_armed && (m_hold == 0);
        m_strobe = fire;
        if (fire) m_stamp = m_count;
        m_count = (m_count + 1) & 16'hFFFF;
        if (fire) m_hold = cfg_hold; else if (m_hold > 0) m_hold--;
        if (fire) m_armed = 0; else if (d < cfg_arm) m_armed = 1;
        m_prevneg = (m_sum < 0);
        m_sum = d - ((x * cfg_f) >>> 8);
        for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
    endtask

    task automatic step(input int x);
        sample_in = 12'(x);
        @(posedge clk);
        model_edge(x);
        ec++;
        @(negedge clk);
        if (strobe !== m_strobe[0] || stamp !== 16'(m_stamp)) mism++;
        if (strobe === 1'b1) begin
            if (nstrobe < 2) begin s_ec[nstrobe] = ec; s_st[nstrobe] = int'(stamp); end
            nstrobe++;
        end
    endtask

    task automatic do_reset(input int n, input int f, input int arm, input int h);
        rst_n = 1'b0;
        sample_in = '0;
        delay_len = 4'(n); frac = 8'(f); arm_level = 12'(arm); holdoff_len = 8'(h);
        cfg_n = (n == 0) ? 1 : n; cfg_f = f; cfg_arm = arm; cfg_hold = h;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        mism = 0; nstrobe = 0;
    endtask

    task automatic pulse(input int shape, input int a);
        if (shape == 1) step(-a);
        else begin step(-a / 2); step(-a); step(-a / 2); step(-a / 4); end
        repeat (40) step(0);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        // R1: reset state with active inputs
        sample_in = -12'sd2048;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(strobe === 1'b0, "R1 strobe in reset", int'(strobe), 0);
        check(stamp === 16'd0, "R1 stamp in reset", int'(stamp), 0);

        // Table walk
        for (int r = 0; r < ROWS; r++) begin
            do_reset(TBL[r][3], TBL[r][4], TBL[r][5], TBL[r][6]);
            repeat (4) step(0);
            pulse(TBL[r][0], TBL[r][1]);
            if (TBL[r][2] != 0) pulse(TBL[r][0], TBL[r][2]);
            check(mism == 0, $sformatf("R%0d row %0d cycle mismatches", TBL[r][8], r), mism, 0);
            check(nstrobe == TBL[r][7], $sformatf("R%0d row %0d strobe count", TBL[r][8], r),
                  nstrobe, TBL[r][7]);
        end

        // R7: timestamps against the bench's own edge count
        do_reset(2, 128, -1, 0);
        repeat (4) step(0);
        pulse(0, 800);
        repeat (7) step(0);
        pulse(0, 600);
        check(nstrobe == 2, "R7 two strobes", nstrobe, 2);
        check(s_st[0] == s_ec[0] - 1, "R7 first stamp", s_st[0], s_ec[0] - 1);
        check(s_st[1] - s_st[0] == s_ec[1] - s_ec[0], "R7 stamp spacing",
              s_st[1] - s_st[0], s_ec[1] - s_ec[0]);

        // R1: reset clears the stamp after activity
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(stamp === 16'd0 && strobe === 1'b0, "R1 stamp after re-reset", int'(stamp), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule